// File: doc/BRIEF.md
# Static-Memory Access Sequencer with Data-Float Wait Insertion

This block turns single commands into timed strobe sequences on an asynchronous static-memory bus that has several chip selects. Each access passes through up to three phases: setup, where the chip select is low and the strobe is still high; pulse, where the strobe is low; and hold, where the strobe is high again and the chip select is still low. Every chip select has its own setup, pulse and hold counts for reads and for writes. A count of zero skips that phase.

After a read, the addressed device may keep driving the data lines for a number of cycles set per chip select. This is the float period. The block follows that period and holds back the next access until the period has run out. Hold cycles of the read count toward the period. If the optimization bit of that chip select is set and the next access goes to the same chip select, the setup cycles of the next access count as well. Any cycles still uncovered become wait cycles, during which every chip select and both strobes are high.

Commands arrive on a valid/ready port. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low the source must hold the command stable. `cmd_ready` is high when the sequencer is idle and also in the final cycle of an access. This lets the next command follow with no dead cycle. The configuration pins are plain levels. They may change only while the sequencer is idle and no float period is pending.

Top module: `smem_float_seq`

## Requirements
- R1: While reset is asserted and on release, `cmd_ready` is 1 and `mem_cs_n`, `mem_rd_n` and `mem_we_n` are all 1.
- R2: A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 during wait, setup, pulse and hold cycles, except in the final cycle of an access.
- R3: For an accepted command to chip select c, bit c of `mem_cs_n` is 0 for the whole setup, pulse and hold phases. `mem_rd_n` (read) or `mem_we_n` (write) is 0 for exactly the pulse cycles. The two strobes are never low together, and a phase with a count of zero takes no cycles.
- R4: `mem_addr` carries the accepted command's address and stays stable for the whole access.
- R5: A read's float period of F cycles starts in the cycle after its last pulse cycle. Without the optimization, no strobe of a later access goes low until F cycles have passed since then.
- R6: Hold cycles of the read count toward its float period. After hold H, at most max(0, F−H) wait cycles remain.
- R7: With the optimization bit of chip select c set, an access to c that follows a read on c gets max(0, F−H−S) wait cycles, where S is its own setup count.
- R8: An access to a different chip select always gets the full remaining float count max(0, F−H) as wait cycles, whatever the optimization bits are set to.
- R9: A write followed by any access inserts no wait cycles.
- R10: During wait cycles all bits of `mem_cs_n` are 1 and both strobes are 1.
- R11: At most one bit of `mem_cs_n` is 0 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready (idle or final cycle of an access) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_cs | input | CS_W | Target chip select index |
| cmd_addr | input | ADDR_W | Access address |
| cfg_rd_setup | input | NUM_CS*CNT_W | Read setup count per chip select, field c at bits c*CNT_W |
| cfg_rd_pulse | input | NUM_CS*CNT_W | Read pulse count per chip select |
| cfg_rd_hold | input | NUM_CS*CNT_W | Read hold count per chip select |
| cfg_wr_setup | input | NUM_CS*CNT_W | Write setup count per chip select |
| cfg_wr_pulse | input | NUM_CS*CNT_W | Write pulse count per chip select |
| cfg_wr_hold | input | NUM_CS*CNT_W | Write hold count per chip select |
| cfg_float | input | NUM_CS*FLT_W | Float cycle count per chip select, field c at bits c*FLT_W |
| cfg_float_opt | input | NUM_CS | Bit c enables the float optimization for chip select c |
| mem_addr | output | ADDR_W | Bus address |
| mem_cs_n | output | NUM_CS | Active-low chip selects, bit c for chip select c |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The hardest situation to reach from the ports is a second command that is already waiting when a read finishes. Only then does the wait count come purely from the float, hold and setup arithmetic, with no idle cycles blurring it. The bench presents the second command in the cycle after the first is accepted and keeps it valid, so it is taken in the read's final cycle. A monitor then counts the cycles from the read strobe's rising edge to the next strobe's falling edge, and separately counts the cycles in that window where every chip select is high. Table rows cover same and different chip selects, the optimization on and off, hold longer than the float period, setup covering the whole remainder, and a zero hold that makes the accept coincide with the last pulse cycle.

// File: rtl/smf_pkg.sv
package smf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WAIT  = 3'd1,
    PH_SETUP = 3'd2,
    PH_PULSE = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;
endpackage

// File: rtl/smf_cfg_select.sv
module smf_cfg_select #(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 6,
  parameter int FLT_W  = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*CNT_W-1:0] rd_setup,
  input  logic [NUM_CS*CNT_W-1:0] rd_pulse,
  input  logic [NUM_CS*CNT_W-1:0] rd_hold,
  input  logic [NUM_CS*CNT_W-1:0] wr_setup,
  input  logic [NUM_CS*CNT_W-1:0] wr_pulse,
  input  logic [NUM_CS*CNT_W-1:0] wr_hold,
  input  logic [NUM_CS*FLT_W-1:0] flt_cnt,
  input  logic [NUM_CS-1:0]       flt_opt,
  input  logic [CS_W-1:0]         cmd_cs,
  input  logic                    cmd_wr,
  input  logic [CS_W-1:0]         cur_cs,
  input  logic [CS_W-1:0]         opt_cs,
  output logic [CNT_W-1:0]        sel_setup,
  output logic [CNT_W-1:0]        sel_pulse,
  output logic [CNT_W-1:0]        sel_hold,
  output logic [FLT_W-1:0]        sel_float,
  output logic                    sel_opt
);
  logic [CNT_W-1:0] rs [NUM_CS];
  logic [CNT_W-1:0] rp [NUM_CS];
  logic [CNT_W-1:0] rh [NUM_CS];
  logic [CNT_W-1:0] ws [NUM_CS];
  logic [CNT_W-1:0] wp [NUM_CS];
  logic [CNT_W-1:0] wh [NUM_CS];
  logic [FLT_W-1:0] fc [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
    assign rs[i] = rd_setup[i*CNT_W +: CNT_W];
    assign rp[i] = rd_pulse[i*CNT_W +: CNT_W];
    assign rh[i] = rd_hold [i*CNT_W +: CNT_W];
    assign ws[i] = wr_setup[i*CNT_W +: CNT_W];
    assign wp[i] = wr_pulse[i*CNT_W +: CNT_W];
    assign wh[i] = wr_hold [i*CNT_W +: CNT_W];
    assign fc[i] = flt_cnt [i*FLT_W +: FLT_W];
  end

  always_comb begin
    sel_setup = cmd_wr ? ws[cmd_cs] : rs[cmd_cs];
    sel_pulse = cmd_wr ? wp[cmd_cs] : rp[cmd_cs];
    sel_hold  = cmd_wr ? wh[cmd_cs] : rh[cmd_cs];
    sel_float = fc[cur_cs];
    sel_opt   = flt_opt[opt_cs];
  end
endmodule

// File: rtl/smf_float_track.sv
module smf_float_track #(
  parameter int CNT_W = 6,
  parameter int FLT_W = 4,
  parameter int CS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_pulse_end,
  input  logic [FLT_W-1:0] load_val,
  input  logic [CS_W-1:0]  cur_cs,
  input  logic [CS_W-1:0]  cmd_cs,
  input  logic [CNT_W-1:0] cmd_setup,
  input  logic             opt_en,
  output logic [FLT_W-1:0] fl_q,
  output logic [CS_W-1:0]  fl_cs_nxt,
  output logic [FLT_W-1:0] wait_cnt
);
  localparam int W = (CNT_W > FLT_W) ? CNT_W : FLT_W;

  logic [FLT_W-1:0] fl_nxt;
  logic [CS_W-1:0]  fl_cs_q;
  logic [W-1:0]     rem_w;
  logic [W-1:0]     setup_w;
  logic [W-1:0]     diff_w;

  // fl_q: float cycles still to elapse, counting the current cycle
  always_comb begin
    if (read_pulse_end)  fl_nxt = load_val;
    else if (fl_q != '0) fl_nxt = fl_q - 1'b1;
    else                 fl_nxt = '0;
    fl_cs_nxt = read_pulse_end ? cur_cs : fl_cs_q;
  end

  always_comb begin
    rem_w   = W'(fl_nxt);
    setup_w = W'(cmd_setup);
    diff_w  = rem_w - setup_w;
    if (fl_nxt == '0)
      wait_cnt = '0;
    else if ((cmd_cs == fl_cs_nxt) && opt_en)
      wait_cnt = (setup_w >= rem_w) ? '0 : FLT_W'(diff_w);
    else
      wait_cnt = fl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q    <= '0;
      fl_cs_q <= '0;
    end else begin
      fl_q    <= fl_nxt;
      fl_cs_q <= fl_cs_nxt;
    end
  end
endmodule

// File: rtl/smf_phase_seq.sv
module smf_phase_seq
  import smf_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FLT_W  = 4,
  parameter int CS_W   = 2,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_setup,
  input  logic [CNT_W-1:0]  cmd_pulse,
  input  logic [CNT_W-1:0]  cmd_hold,
  input  logic [FLT_W-1:0]  wait_cnt,
  output logic              cmd_ready,
  output phase_e            phase_q,
  output logic [CS_W-1:0]   cs_q,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              read_pulse_end
);
  logic [CNT_W-1:0] cnt_q, s_q, p_q, h_q;
  phase_e           nxt_ph, first_ph;
  logic             accept;

  function automatic phase_e after_ph(input phase_e cur, input logic [CNT_W-1:0] s,
                                      input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] h);
    phase_e r;
    r = PH_IDLE;
    if (cur == PH_WAIT && s != '0)
      r = PH_SETUP;
    else if ((cur == PH_WAIT || cur == PH_SETUP) && p != '0)
      r = PH_PULSE;
    else if (cur != PH_HOLD && cur != PH_IDLE && h != '0)
      r = PH_HOLD;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] len_of(input phase_e ph, input logic [CNT_W-1:0] w,
                                              input logic [CNT_W-1:0] s, input logic [CNT_W-1:0] p,
                                              input logic [CNT_W-1:0] h);
    logic [CNT_W-1:0] r;
    case (ph)
      PH_WAIT:  r = w;
      PH_SETUP: r = s;
      PH_PULSE: r = p;
      PH_HOLD:  r = h;
      default:  r = '0;
    endcase
    return r;
  endfunction

  always_comb begin
    nxt_ph    = after_ph(phase_q, s_q, p_q, h_q);
    cmd_ready = (phase_q == PH_IDLE) || (cnt_q == 1 && nxt_ph == PH_IDLE);
    accept    = cmd_valid && cmd_ready;
    first_ph  = (wait_cnt != '0) ? PH_WAIT : after_ph(PH_WAIT, cmd_setup, cmd_pulse, cmd_hold);
    read_pulse_end = (phase_q == PH_PULSE) && (cnt_q == 1) && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      s_q     <= '0;
      p_q     <= '0;
      h_q     <= '0;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
    end else if (accept) begin
      phase_q <= first_ph;
      cnt_q   <= len_of(first_ph, CNT_W'(wait_cnt), cmd_setup, cmd_pulse, cmd_hold);
      s_q     <= cmd_setup;
      p_q     <= cmd_pulse;
      h_q     <= cmd_hold;
      cs_q    <= cmd_cs;
      wr_q    <= cmd_write;
      addr_q  <= cmd_addr;
    end else if (phase_q != PH_IDLE) begin
      if (cnt_q == 1) begin
        phase_q <= nxt_ph;
        cnt_q   <= len_of(nxt_ph, '0, s_q, p_q, h_q);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/smem_float_seq.sv
module smem_float_seq
  import smf_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6,
  parameter int FLT_W  = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_write,
  input  logic [CS_W-1:0]         cmd_cs,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [NUM_CS*CNT_W-1:0] cfg_rd_setup,
  input  logic [NUM_CS*CNT_W-1:0] cfg_rd_pulse,
  input  logic [NUM_CS*CNT_W-1:0] cfg_rd_hold,
  input  logic [NUM_CS*CNT_W-1:0] cfg_wr_setup,
  input  logic [NUM_CS*CNT_W-1:0] cfg_wr_pulse,
  input  logic [NUM_CS*CNT_W-1:0] cfg_wr_hold,
  input  logic [NUM_CS*FLT_W-1:0] cfg_float,
  input  logic [NUM_CS-1:0]       cfg_float_opt,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic                    mem_rd_n,
  output logic                    mem_we_n
);
  logic [CNT_W-1:0] sel_setup, sel_pulse, sel_hold;
  logic [FLT_W-1:0] sel_float, fl_q, wait_cnt;
  logic             sel_opt, wr_q, read_pulse_end;
  logic [CS_W-1:0]  cs_q, fl_cs_nxt;
  phase_e           phase_q;
  logic             in_access;

  smf_cfg_select #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .FLT_W(FLT_W), .CS_W(CS_W)) u_cfg (
    .rd_setup(cfg_rd_setup), .rd_pulse(cfg_rd_pulse), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_pulse(cfg_wr_pulse), .wr_hold(cfg_wr_hold),
    .flt_cnt(cfg_float), .flt_opt(cfg_float_opt),
    .cmd_cs(cmd_cs), .cmd_wr(cmd_write), .cur_cs(cs_q), .opt_cs(fl_cs_nxt),
    .sel_setup(sel_setup), .sel_pulse(sel_pulse), .sel_hold(sel_hold),
    .sel_float(sel_float), .sel_opt(sel_opt)
  );

  smf_float_track #(.CNT_W(CNT_W), .FLT_W(FLT_W), .CS_W(CS_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .read_pulse_end(read_pulse_end), .load_val(sel_float),
    .cur_cs(cs_q), .cmd_cs(cmd_cs), .cmd_setup(sel_setup), .opt_en(sel_opt),
    .fl_q(fl_q), .fl_cs_nxt(fl_cs_nxt), .wait_cnt(wait_cnt)
  );

  smf_phase_seq #(.CNT_W(CNT_W), .FLT_W(FLT_W), .CS_W(CS_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_cs(cmd_cs), .cmd_addr(cmd_addr), .cmd_setup(sel_setup), .cmd_pulse(sel_pulse),
    .cmd_hold(sel_hold), .wait_cnt(wait_cnt), .cmd_ready(cmd_ready), .phase_q(phase_q),
    .cs_q(cs_q), .wr_q(wr_q), .addr_q(mem_addr), .read_pulse_end(read_pulse_end)
  );

  assign in_access = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) || (phase_q == PH_HOLD);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign mem_cs_n[i] = !(in_access && (cs_q == CS_W'(i)));
  end

  assign mem_rd_n = !((phase_q == PH_PULSE) && !wr_q);
  assign mem_we_n = !((phase_q == PH_PULSE) && wr_q);
endmodule

// File: rtl/smf_checker.sv
module smf_checker
  import smf_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int FLT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [FLT_W-1:0]  fl_q,
  input phase_e            phase
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_rd_n && !mem_we_n)); // R3
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_rd_n || !mem_we_n) |-> (~mem_cs_n != '0)); // R3
  AST_NO_STROBE_IN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n) (!mem_rd_n || !mem_we_n) |-> (fl_q == '0)); // R5
  AST_WAIT_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_WAIT) |-> (&mem_cs_n && mem_rd_n && mem_we_n)); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_rd_n && $past(!mem_rd_n)) |-> $stable(mem_addr)); // R4
endmodule

bind smem_float_seq smf_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .FLT_W(FLT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .fl_q(fl_q), .phase(phase_q)
);

// File: tb/smem_float_seq_tb.sv
`timescale 1ns/1ps
module smem_float_seq_tb;
  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int CW  = 6;
  localparam int FW  = 4;

  typedef struct packed {
    logic [1:0] c1;
    logic [1:0] c2;
    logic       wr2;
    logic [5:0] h;
    logic [3:0] f;
    logic       opt;
    logic [5:0] s2;
    logic [7:0] g;
    logic [3:0] w;
  } vec_t;

  // c1 reads, then c2 accesses; g = cycles from read strobe rise to next strobe fall, w = wait cycles
  localparam vec_t VEC [10] = '{
    '{2'd0, 2'd0, 1'b1, 6'd4, 4'd6,  1'b1, 6'd3, 8'd7,  4'd0},
    '{2'd0, 2'd0, 1'b1, 6'd4, 4'd6,  1'b0, 6'd3, 8'd9,  4'd2},
    '{2'd0, 2'd1, 1'b1, 6'd4, 4'd6,  1'b1, 6'd3, 8'd9,  4'd2},
    '{2'd0, 2'd1, 1'b0, 6'd4, 4'd6,  1'b1, 6'd3, 8'd9,  4'd2},
    '{2'd2, 2'd2, 1'b0, 6'd0, 4'd6,  1'b1, 6'd2, 8'd6,  4'd4},
    '{2'd2, 2'd2, 1'b0, 6'd0, 4'd6,  1'b0, 6'd2, 8'd8,  4'd6},
    '{2'd1, 2'd3, 1'b1, 6'd5, 4'd3,  1'b0, 6'd1, 8'd6,  4'd0},
    '{2'd3, 2'd3, 1'b1, 6'd1, 4'd15, 1'b1, 6'd4, 8'd15, 4'd10},
    '{2'd3, 2'd0, 1'b0, 6'd2, 4'd0,  1'b0, 6'd1, 8'd3,  4'd0},
    '{2'd1, 2'd1, 1'b1, 6'd0, 4'd5,  1'b1, 6'd5, 8'd5,  4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [1:0] cmd_cs = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NCS*CW-1:0] rs, rp, rh, ws, wp, wh;
  logic [NCS*FW-1:0] fc;
  logic [NCS-1:0] op;
  logic [AW-1:0] mem_addr;
  logic [NCS-1:0] mem_cs_n;
  logic mem_rd_n, mem_we_n;

  int nchk = 0, nerr = 0;
  int gaps = 0, gap_len = 0, idle_len = 0, last_plen = 0;
  int plen = 0, gcnt = 0, icnt = 0;
  bit armed = 0, prev_lo = 0;

  always #4 clk = ~clk;

  smem_float_seq #(.NUM_CS(NCS), .ADDR_W(AW), .CNT_W(CW), .FLT_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_cs(cmd_cs), .cmd_addr(cmd_addr),
    .cfg_rd_setup(rs), .cfg_rd_pulse(rp), .cfg_rd_hold(rh),
    .cfg_wr_setup(ws), .cfg_wr_pulse(wp), .cfg_wr_hold(wh),
    .cfg_float(fc), .cfg_float_opt(op),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n)
  );

  // strobe gap monitor
  always @(negedge clk) begin
    bit lo;
    lo = !mem_rd_n || !mem_we_n;
    if (lo) plen = prev_lo ? plen + 1 : 1;
    if (prev_lo && !lo) begin
      armed = 1; gcnt = 1; icnt = (&mem_cs_n) ? 1 : 0; last_plen = plen;
    end else if (armed) begin
      if (lo) begin
        gap_len = gcnt; idle_len = icnt; armed = 0; gaps++;
      end else begin
        gcnt++;
        if (&mem_cs_n) icnt++;
        if (gcnt > 25) armed = 0;
      end
    end
    prev_lo = lo;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_defaults();
    for (int c = 0; c < NCS; c++) begin
      rs[c*CW +: CW] = 6'd1; rp[c*CW +: CW] = 6'd2; rh[c*CW +: CW] = 6'd0;
      ws[c*CW +: CW] = 6'd1; wp[c*CW +: CW] = 6'd2; wh[c*CW +: CW] = 6'd1;
      fc[c*FW +: FW] = 4'd0; op[c] = 1'b0;
    end
  endtask

  task automatic issue(input int cs, input bit wr, input logic [AW-1:0] a);
    cmd_valid = 1'b1; cmd_cs = 2'(cs); cmd_write = wr; cmd_addr = a;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_gap(input int base, input string tag);
    for (int k = 0; k < 80 && gaps == base; k++) @(negedge clk);
    if (gaps == base) check(1'b0, tag, 0, 1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    string tag;
    vec_t v;
    set_defaults();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_ready == 1'b1, "R1 ready in reset", int'(cmd_ready), 1);
    check(mem_cs_n == 4'hF, "R1 cs_n in reset", int'(mem_cs_n), 15);
    check(mem_rd_n && mem_we_n, "R1 strobes in reset", int'({mem_rd_n, mem_we_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && mem_cs_n == 4'hF, "R1 after release", int'(mem_cs_n), 15);

    // table walk: read then second access presented early
    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      set_defaults();
      rh[v.c1*CW +: CW] = v.h; fc[v.c1*FW +: FW] = v.f; op[v.c1] = v.opt;
      if (v.wr2) ws[v.c2*CW +: CW] = v.s2; else rs[v.c2*CW +: CW] = v.s2;
      repeat (2) @(negedge clk);
      base = gaps;
      issue(v.c1, 1'b0, 24'h100000 + 24'(i));
      issue(v.c2, v.wr2, 24'h200000 + 24'(i));
      cmd_valid = 1'b0;
      if (v.c1 != v.c2) tag = "R8 gap";
      else if (v.opt) tag = "R7 gap";
      else if (v.h != 0) tag = "R6 gap";
      else tag = "R5 gap";
      wait_gap(base, tag);
      check(gap_len == int'(v.g), tag, gap_len, int'(v.g));
      check(idle_len == int'(v.w), "R10 wait cycles", idle_len, int'(v.w));
      repeat (30) @(negedge clk);
    end

    // directed: ready, chip select, address and pulse width
    set_defaults();
    rs[1*CW +: CW] = 6'd3; rh[1*CW +: CW] = 6'd1;
    @(negedge clk);
    issue(1, 1'b0, 24'h001234);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R2 ready low in setup", int'(cmd_ready), 0);
    check(mem_cs_n == 4'b1101, "R3 cs select", int'(mem_cs_n), 13);
    check(mem_addr == 24'h001234, "R4 address", int'(mem_addr), 32'h1234);
    repeat (3) @(negedge clk);
    check(mem_rd_n == 1'b0, "R3 read strobe in pulse", int'(mem_rd_n), 0);
    repeat (10) @(negedge clk);
    check(last_plen == 2, "R3 pulse width", last_plen, 2);

    // directed: write then read adds no float wait
    set_defaults();
    wh[0*CW +: CW] = 6'd2; fc[0*FW +: FW] = 4'd6;
    repeat (30) @(negedge clk);
    base = gaps;
    issue(0, 1'b1, 24'h00AAAA);
    issue(1, 1'b0, 24'h00BBBB);
    cmd_valid = 1'b0;
    wait_gap(base, "R9 gap");
    check(gap_len == 3, "R9 gap", gap_len, 3);
    check(idle_len == 0, "R9 wait cycles", idle_len, 0);

    // directed: zero setup and hold skip their phases
    set_defaults();
    ws[2*CW +: CW] = 6'd0; wp[2*CW +: CW] = 6'd1; wh[2*CW +: CW] = 6'd0;
    repeat (30) @(negedge clk);
    issue(2, 1'b1, 24'h000042);
    cmd_valid = 1'b0;
    check(mem_we_n == 1'b0, "R3 zero setup skipped", int'(mem_we_n), 0);
    check(mem_cs_n == 4'b1011, "R3 cs during single pulse", int'(mem_cs_n), 11);
    check(cmd_ready == 1'b1, "R2 ready in final cycle", int'(cmd_ready), 1);
    @(negedge clk);
    check(mem_we_n && mem_cs_n == 4'hF, "R3 zero hold skipped", int'(mem_cs_n), 15);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule